// File: doc/BRIEF.md
# Software Interrupt Pending Register

This block holds a 32-bit vector of software-requested interrupt lines. Privileged code changes it through three operations: it can turn bits on, turn bits off, or replace the whole vector. The operand for each operation is the exclusive-OR of two 64-bit source values, and only its low 32 bits are used. The stored vector goes to an interrupt evaluation unit, which sits outside this block.

The evaluation unit only needs to look again when the vector really changes. The block therefore sends it a one-cycle recheck strobe when an operation alters the stored value while interrupts are globally enabled. If an operation is issued outside supervisor mode, the register is left alone and an illegal-operation flag is raised for the trap logic. Operation codes that do not belong to this block pass through with no effect.

Top module: `swint_pending`

## Requirements
- R1: A synchronous active-high reset clears the pending vector, the recheck strobe and the illegal flag to zero.
- R2: Operation code 0x16 (write) loads the pending vector with the low 32 bits of src1 XOR src2. The upper 32 source bits have no effect. The new value is visible in the cycle after the operation.
- R3: Operation code 0x14 (set) loads the pending vector with its old value OR the operand.
- R4: Operation code 0x15 (clear) loads the pending vector with its old value AND the inverted operand.
- R5: Any other operation code leaves the vector unchanged and raises neither the strobe nor the illegal flag.
- R6: If code 0x14, 0x15 or 0x16 is presented while the supervisor flag is low, the vector stays unchanged, no strobe is raised, and the illegal flag is high in the next cycle.
- R7: If a legal operation changes the vector while interrupt enable is high, the recheck strobe is high for exactly the one cycle after the operation.
- R8: If a legal operation leaves the vector at its old value, no recheck strobe is raised.
- R9: If interrupt enable is low, a legal operation still updates the vector but raises no recheck strobe.
- R10: The illegal flag is high only in the cycle that follows an offending operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| op_i | input | 6 | Operation code; 0x14 set, 0x15 clear, 0x16 write |
| src1_i | input | 64 | First source operand |
| src2_i | input | 64 | Second source operand |
| priv_i | input | 1 | High when the issuer is in supervisor mode |
| ien_i | input | 1 | Global interrupt enable |
| pend_o | output | 32 | Stored pending vector |
| recheck_o | output | 1 | One-cycle request to re-evaluate interrupts |
| illegal_o | output | 1 | Operation attempted outside supervisor mode |

## Verification
The assertions assume that an operation code is presented for exactly one clock cycle and that each cycle is an independent request. They also assume the inputs are never X once reset has been released. The stimulus drives a new, fully defined set of inputs on every falling edge.

To exercise R8, the stimulus often makes the two sources equal or reuses the stored value. This produces operations that leave the vector unchanged, which is the case where the strobe must stay quiet. It also mixes in non-supervisor requests and codes next to the valid range, so that the illegal and ignore paths are covered by both directed and random stimulus.

// File: rtl/swint_pkg.sv
package swint_pkg;
   typedef enum logic [1:0] {
      SW_NONE = 2'd0,
      SW_OR   = 2'd1,
      SW_ANDN = 2'd2,
      SW_LOAD = 2'd3
   } sw_kind_e;
endpackage

// File: rtl/swint_decode.sv
module swint_decode
   import swint_pkg::*;
#(
   parameter int unsigned OP_W = 6,
   parameter logic [OP_W-1:0] CODE_SET = 'h14,
   parameter logic [OP_W-1:0] CODE_CLR = 'h15,
   parameter logic [OP_W-1:0] CODE_WR  = 'h16
) (
   input  logic [OP_W-1:0] op_i,
   output sw_kind_e        kind_o
);
   always_comb begin
      kind_o = SW_NONE;
      if (op_i == CODE_SET)      kind_o = SW_OR;
      else if (op_i == CODE_CLR) kind_o = SW_ANDN;
      else if (op_i == CODE_WR)  kind_o = SW_LOAD;
   end
endmodule

// File: rtl/swint_operand.sv
module swint_operand #(
   parameter int unsigned SRC_W = 64,
   parameter int unsigned REG_W = 32
) (
   input  logic [SRC_W-1:0] src1_i,
   input  logic [SRC_W-1:0] src2_i,
   output logic [REG_W-1:0] opnd_o
);
   generate
      if (REG_W == SRC_W) begin : g_full
         assign opnd_o = src1_i ^ src2_i;
      end else begin : g_trunc
         logic unused_hi;
         assign unused_hi = ^{src1_i[SRC_W-1:REG_W], src2_i[SRC_W-1:REG_W]};
         assign opnd_o    = src1_i[REG_W-1:0] ^ src2_i[REG_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/swint_next.sv
module swint_next
   import swint_pkg::*;
#(
   parameter int unsigned REG_W = 32
) (
   input  logic [REG_W-1:0] cur_i,
   input  logic [REG_W-1:0] opnd_i,
   input  sw_kind_e         kind_i,
   input  logic             priv_i,
   output logic [REG_W-1:0] nxt_o,
   output logic             upd_o
);
   always_comb begin
      unique case (kind_i)
         SW_OR:   nxt_o = cur_i | opnd_i;
         SW_ANDN: nxt_o = cur_i & ~opnd_i;
         SW_LOAD: nxt_o = opnd_i;
         default: nxt_o = cur_i;
      endcase
   end
   assign upd_o = priv_i && (kind_i != SW_NONE);
endmodule

// File: rtl/swint_pending.sv
module swint_pending
   import swint_pkg::*;
#(
   parameter int unsigned SRC_W = 64,
   parameter int unsigned REG_W = 32,
   parameter int unsigned OP_W  = 6,
   parameter logic [OP_W-1:0] CODE_SET = 'h14,
   parameter logic [OP_W-1:0] CODE_CLR = 'h15,
   parameter logic [OP_W-1:0] CODE_WR  = 'h16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [OP_W-1:0]  op_i,
   input  logic [SRC_W-1:0] src1_i,
   input  logic [SRC_W-1:0] src2_i,
   input  logic             priv_i,
   input  logic             ien_i,
   output logic [REG_W-1:0] pend_o,
   output logic             recheck_o,
   output logic             illegal_o
);
   localparam logic [REG_W-1:0] ZERO = '0;

   generate
      if (REG_W == 0 || REG_W > SRC_W) begin : g_bad_width
         $error("swint_pending: REG_W must be 1..SRC_W");
      end
      if (CODE_SET == CODE_CLR || CODE_SET == CODE_WR || CODE_CLR == CODE_WR) begin : g_bad_codes
         $error("swint_pending: operation codes must be distinct");
      end
   endgenerate

   sw_kind_e         kind;
   logic [REG_W-1:0] opnd;
   logic [REG_W-1:0] nxt;
   logic             upd;
   logic [REG_W-1:0] pend_q;
   logic             recheck_q;
   logic             ill_q;

   swint_decode #(.OP_W(OP_W), .CODE_SET(CODE_SET), .CODE_CLR(CODE_CLR), .CODE_WR(CODE_WR))
      i_decode (.op_i(op_i), .kind_o(kind));

   swint_operand #(.SRC_W(SRC_W), .REG_W(REG_W))
      i_operand (.src1_i(src1_i), .src2_i(src2_i), .opnd_o(opnd));

   swint_next #(.REG_W(REG_W))
      i_next (.cur_i(pend_q), .opnd_i(opnd), .kind_i(kind), .priv_i(priv_i),
              .nxt_o(nxt), .upd_o(upd));

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pend_q    <= ZERO;
         recheck_q <= 1'b0;
         ill_q     <= 1'b0;
      end else begin
         ill_q     <= (kind != SW_NONE) && !priv_i;
         recheck_q <= upd && ien_i && (nxt != pend_q);
         if (upd) pend_q <= nxt;
      end
   end

   assign pend_o    = pend_q;
   assign recheck_o = recheck_q;
   assign illegal_o = ill_q;

   // R2: write loads the truncated XOR operand
   p_write_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (priv_i && op_i == CODE_WR) |=> (pend_o == $past(opnd)));
   // R3: set leaves every operand bit on
   p_set_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (priv_i && op_i == CODE_SET) |=> ((pend_o & $past(opnd)) == $past(opnd)));
   // R4: clear leaves every operand bit off
   p_clear_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      (priv_i && op_i == CODE_CLR) |=> ((pend_o & $past(opnd)) == ZERO));
   // R5: foreign codes touch nothing
   p_foreign_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (op_i != CODE_SET && op_i != CODE_CLR && op_i != CODE_WR)
      |=> ($stable(pend_o) && !recheck_o && !illegal_o));
   // R6: user-mode attempts are flagged and blocked
   p_user_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (!priv_i && (op_i == CODE_SET || op_i == CODE_CLR || op_i == CODE_WR))
      |=> (illegal_o && $stable(pend_o) && !recheck_o));
   // R7, R9: strobe implies a real change with interrupts enabled
   p_strobe_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      recheck_o |-> (pend_o != $past(pend_o)) && $past(ien_i));
   // R8: no change, no strobe
   p_quiet_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      (pend_o == $past(pend_o)) |-> !recheck_o);
   // R10: illegal flag only right after an offending op
   p_ill_once_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      illegal_o |-> $past(!priv_i && (op_i == CODE_SET || op_i == CODE_CLR || op_i == CODE_WR)));
endmodule

// File: tb/test_swint_pending.sv
module test_swint_pending;
   logic        clk = 1'b0;
   logic        rst;
   logic [5:0]  op;
   logic [63:0] s1, s2;
   logic        priv, ien;
   logic [31:0] pend;
   logic        recheck, illegal;

   int unsigned n_vec = 0;
   int unsigned n_bad = 0;
   logic [31:0] model = '0;

   always #2.5 clk = ~clk;

   swint_pending i_swint_pending (
      .clk_i(clk), .rst_i(rst), .op_i(op), .src1_i(s1), .src2_i(s2),
      .priv_i(priv), .ien_i(ien), .pend_o(pend), .recheck_o(recheck), .illegal_o(illegal));

   function automatic logic [31:0] exp_next(logic [31:0] cur, logic [5:0] c, logic [31:0] x);
      case (c)
         6'h14:   return cur | x;
         6'h15:   return cur & ~x;
         6'h16:   return x;
         default: return cur;
      endcase
   endfunction

   function automatic bit is_mine(logic [5:0] c);
      return c == 6'h14 || c == 6'h15 || c == 6'h16;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic step(logic [5:0] c, logic [63:0] a, logic [63:0] b, logic p, logic e);
      logic [31:0] x, nv;
      bit          legal;
      string       t_val, t_str, t_ill;
      @(negedge clk);
      op = c; s1 = a; s2 = b; priv = p; ien = e;
      x     = a[31:0] ^ b[31:0];
      legal = p && is_mine(c);
      nv    = legal ? exp_next(model, c, x) : model;
      if (!is_mine(c))      t_val = "R5";
      else if (!p)          t_val = "R6";
      else if (c == 6'h14)  t_val = "R3";
      else if (c == 6'h15)  t_val = "R4";
      else                  t_val = "R2";
      if (nv == model)      t_str = "R8";
      else if (!e)          t_str = "R9";
      else                  t_str = "R7";
      t_ill = (is_mine(c) && !p) ? "R6" : "R10";
      @(posedge clk); #1;
      chk(t_val, pend, nv);
      chk(t_str, {31'd0, recheck}, {31'd0, (nv != model) && e});
      chk(t_ill, {31'd0, illegal}, {31'd0, is_mine(c) && !p});
      model = nv;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; op = 6'h14; s1 = '1; s2 = '0; priv = 1'b1; ien = 1'b1;
      @(posedge clk); #1;
      model = '0;
      chk("R1", pend, 32'd0);
      chk("R1", {30'd0, recheck, illegal}, 32'd0);
      @(negedge clk);
      rst = 1'b0; op = 6'h00;
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [63:0] ra, rb;
      logic [5:0]  rc;
      void'($urandom(32'h5eed_1234));
      rst = 1'b1; op = '0; s1 = '0; s2 = '0; priv = 1'b0; ien = 1'b0;
      repeat (2) @(posedge clk);
      do_reset();
      // R2: upper source bits ignored, operand is low-half XOR
      step(6'h16, 64'hFFFF_0000_1234_5678, 64'hABCD_0000_0000_00FF, 1'b1, 1'b1);
      // R7: next op with no change, strobe must drop after one cycle (R8)
      step(6'h14, 64'h0, 64'h0, 1'b1, 1'b1);
      // R3
      step(6'h14, 64'h8000_0000, 64'h1, 1'b1, 1'b1);
      // R4
      step(6'h15, 64'h1234_0000, 64'h0000_0078, 1'b1, 1'b1);
      // R8: write same value
      step(6'h16, {32'h0, model}, 64'h0, 1'b1, 1'b1);
      // R9: change with interrupts disabled
      step(6'h16, 64'hCAFE_F00D, 64'h0, 1'b1, 1'b0);
      // R6: user mode on each code
      step(6'h14, 64'hFFFF_FFFF, 64'h0, 1'b0, 1'b1);
      step(6'h15, 64'hFFFF_FFFF, 64'h0, 1'b0, 1'b1);
      step(6'h16, 64'h0, 64'h1, 1'b0, 1'b1);
      // R10: flag drops on the following legal op
      step(6'h15, 64'h0000_000D, 64'h0, 1'b1, 1'b1);
      // R5: neighbouring codes
      step(6'h13, 64'hFFFF_FFFF, 64'h0, 1'b1, 1'b1);
      step(6'h17, 64'hFFFF_FFFF, 64'h0, 1'b0, 1'b1);
      for (int i = 0; i < 400; i++) begin
         ra = {$urandom, $urandom};
         rb = ($urandom % 4 == 0) ? ra : {$urandom, $urandom};
         case ($urandom % 6)
            0: rc = 6'h13;
            1: rc = 6'h17;
            2: rc = 6'($urandom);
            3: rc = 6'h14;
            4: rc = 6'h15;
            default: rc = 6'h16;
         endcase
         step(rc, ra, rb, ($urandom % 8) != 0, ($urandom % 4) != 0);
      end
      do_reset();
      step(6'h16, 64'h1, 64'h0, 1'b1, 1'b1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule